// File: doc/BRIEF.md
# Protected Sector Write Sequencer

This block is the control core of a small in-system-programmable byte memory. It watches qualified write events (a one-cycle strobe with a 16-bit address and an 8-bit data byte). No data reaches the storage array until a fixed three-write command prefix has been seen. After that prefix, a load window opens. Writes in the window fill a 128-byte sector staging buffer, in any order. The window closes once no write has arrived for a configurable number of timebase ticks.

When the window closes, the block holds busy for a timed program period. It then commits the whole sector to the storage array in one pass, one byte per clock. Every byte that was not loaded is written as FFh, so the sector is erased and programmed in the same pass. A write that does not follow the command prefix still starts a busy period of the same length, but it stores nothing. Status outputs feed an external read path: busy, a polling toggle, and the address and data of the last byte taken. All waiting is counted in cycles where the `tick` input is high.

Top module: `sector_write_seq`

## Requirements
- R1: After synchronous reset, busy, poll_toggle, last_addr and last_data are all zero.
- R2: The command prefix is three writes in this order: AAh to 5555h, then 55h to 2AAAh, then A0h to 5555h. A correct first or second step leaves busy low. The third step opens a load window. Loads are taken only inside a window.
- R3: While idle, a write that breaks the prefix at any step resets the prefix detector. It raises busy in the next cycle for PROG_TICKS ticks and leaves the array unchanged. That write is also captured in last_addr and last_data.
- R4: Address bits 15..7 select the sector and bits 6..0 select the byte within it. Bytes may be loaded in any order. A second load to the same byte replaces the first.
- R5: The first load fixes the window's sector. A later load to a different sector is discarded: it changes neither the buffer nor last_addr or last_data. It does not end the window, and it restarts the idle timer.
- R6: Busy rises IDLE_TICKS ticks after the clock edge that sampled the last write of the window.
- R7: After PROG_TICKS further ticks, the 128 bytes of the sector are written to the array on 128 consecutive clocks, in ascending byte order. Unloaded bytes become FFh. Busy falls on the clock after the last of these writes.
- R8: Write strobes that arrive while busy have no effect. This includes writes that form a complete command prefix.
- R9: poll_toggle inverts on every ticked clock while busy is high, and holds its value while busy is low.
- R10: While tick is low, the idle and program timers do not advance.
- R11: last_addr and last_data show the address and data of the most recent accepted load.
- R12: Every program operation needs a new command prefix. A plain write after a completed commit is treated as an R3 write.
- R13: The array stores STORE_SECTORS sectors; the sector number is taken modulo STORE_SECTORS. The read port returns the byte at rd_addr one clock after rd_addr is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase enable; timers advance only when it is high |
| wr_stb | input | 1 | One-cycle qualified write strobe |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 16 | Array read address |
| rd_data | output | 8 | Array read data, one clock latency |
| busy | output | 1 | Program or stray-write period in progress |
| poll_toggle | output | 1 | Status bit that flips each ticked cycle while busy |
| last_addr | output | 16 | Address of the last accepted byte |
| last_data | output | 8 | Data of the last accepted byte |

## Verification
Counting from the clock edge that samples a write, busy rises after IDLE_TICKS edges for a real load window. For a stray write it rises after one edge. It then stays high for PROG_TICKS + 128 edges after a load window, or for PROG_TICKS edges after a stray write. The bench samples busy on the falling edge just before and just after each of these boundaries, so an off-by-one at either end is caught. Array contents are checked through a scoreboard. The driver queues each expected byte when it presents rd_addr, and the monitor compares rd_data on the falling edge after the next rising edge, which matches the one-clock read latency. last_addr and last_data are sampled on the falling edge after the write edge, since they update on that edge.

// File: rtl/sws_pkg.sv
package sws_pkg;

    localparam int ADDR_W       = 16;
    localparam int DATA_W       = 8;
    localparam int BYTE_IDX_W   = 7;
    localparam int SECTOR_BYTES = 1 << BYTE_IDX_W;
    localparam int SECT_NUM_W   = ADDR_W - BYTE_IDX_W;

    localparam logic [ADDR_W-1:0] CMD_ADDR_MAIN = 16'h5555;
    localparam logic [ADDR_W-1:0] CMD_ADDR_ALT  = 16'h2AAA;
    localparam logic [DATA_W-1:0] CMD_DATA_0    = 8'hAA;
    localparam logic [DATA_W-1:0] CMD_DATA_1    = 8'h55;
    localparam logic [DATA_W-1:0] CMD_DATA_2    = 8'hA0;
    localparam logic [DATA_W-1:0] ERASED_BYTE   = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PROG,
        ST_COMMIT,
        ST_STRAY
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_evt_t;

    function automatic wr_evt_t unlock_step(input logic [1:0] idx);
        wr_evt_t s;
        case (idx)
            2'd0:    begin s.addr = CMD_ADDR_MAIN; s.data = CMD_DATA_0; end
            2'd1:    begin s.addr = CMD_ADDR_ALT;  s.data = CMD_DATA_1; end
            default: begin s.addr = CMD_ADDR_MAIN; s.data = CMD_DATA_2; end
        endcase
        return s;
    endfunction

    function automatic logic [SECT_NUM_W-1:0] sector_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:BYTE_IDX_W];
    endfunction

    function automatic logic [BYTE_IDX_W-1:0] byte_of(input logic [ADDR_W-1:0] a);
        return a[BYTE_IDX_W-1:0];
    endfunction

endpackage

// File: rtl/sws_unlock_det.sv
module sws_unlock_det
    import sws_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    enable,
    input  logic    stb,
    input  wr_evt_t evt,
    output logic    open_pulse,
    output logic    miss_pulse
);

    logic [1:0] step;
    wr_evt_t    want;
    logic       match;

    always_comb begin
        want       = unlock_step(step);
        match      = (evt == want);
        open_pulse = enable && stb && match && (step == 2'd2);
        miss_pulse = enable && stb && !match;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            step <= 2'd0;
        end else if (stb) begin
            if (match && step != 2'd2) step <= step + 2'd1;
            else                       step <= 2'd0;
        end
    end

endmodule

// File: rtl/sws_sector_buf.sv
module sws_sector_buf #(
    parameter int BYTES = 128,
    parameter int DW    = 8,
    localparam int IW   = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx,
    output logic [DW-1:0] rdata,
    output logic          any_valid
);

    logic [DW-1:0]    slot [BYTES];
    logic [BYTES-1:0] vld;

    always_ff @(posedge clk) begin
        if (we) slot[widx] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clear)  vld <= '0;
        else if (we)       vld[widx] <= 1'b1;
    end

    always_comb begin
        rdata     = vld[ridx] ? slot[ridx] : {DW{1'b1}};
        any_valid = |vld;
    end

endmodule

// File: rtl/sws_cell_array.sv
module sws_cell_array #(
    parameter int WORDS = 2048,
    parameter int DW    = 8,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
        rdata <= cells[raddr];
    end

endmodule

// File: rtl/sector_write_seq.sv
module sector_write_seq
    import sws_pkg::*;
#(
    parameter int IDLE_TICKS    = 20,
    parameter int PROG_TICKS    = 40,
    parameter int STORE_SECTORS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        wr_stb,
    input  logic [15:0] wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [15:0] rd_addr,
    output logic [7:0]  rd_data,
    output logic        busy,
    output logic        poll_toggle,
    output logic [15:0] last_addr,
    output logic [7:0]  last_data
);

    localparam int CNT_MAX    = (IDLE_TICKS > PROG_TICKS) ? IDLE_TICKS : PROG_TICKS;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);
    localparam int SEC_STO_W  = $clog2(STORE_SECTORS);
    localparam int ARR_WORDS  = STORE_SECTORS * SECTOR_BYTES;
    localparam int ARR_AW     = SEC_STO_W + BYTE_IDX_W;
    localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(IDLE_TICKS - 1);
    localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_TICKS - 1);
    localparam logic [BYTE_IDX_W-1:0] IDX_LAST = {BYTE_IDX_W{1'b1}};

    seq_state_e               state;
    logic [CNT_W-1:0]         cnt;
    logic [BYTE_IDX_W-1:0]    commit_idx;
    logic [SECT_NUM_W-1:0]    win_sector;
    wr_evt_t                  evt;
    logic                     det_en;
    logic                     unlock_open;
    logic                     stray_hit;
    logic                     any_loaded;
    logic                     load_accept;
    logic                     mem_we;
    logic [DATA_W-1:0]        commit_byte;
    logic [ARR_AW-1:0]        mem_waddr;
    logic [ARR_AW-1:0]        mem_raddr;
    logic [SECT_NUM_W-1:0]    rd_sector;
    logic [SECT_NUM_W-1:0]    rd_sector_mod;
    logic [SECT_NUM_W-1:0]    win_sector_mod;

    always_comb begin
        evt.addr    = wr_addr;
        evt.data    = wr_data;
        det_en      = (state == ST_IDLE);
        busy        = (state == ST_PROG) || (state == ST_COMMIT) || (state == ST_STRAY);
        load_accept = (state == ST_LOAD) && wr_stb &&
                      (!any_loaded || sector_of(wr_addr) == win_sector);
        mem_we      = (state == ST_COMMIT);
    end

    sws_unlock_det u_unlock (
        .clk        (clk),
        .rst        (rst),
        .enable     (det_en),
        .stb        (wr_stb),
        .evt        (evt),
        .open_pulse (unlock_open),
        .miss_pulse (stray_hit)
    );

    sws_sector_buf #(
        .BYTES (SECTOR_BYTES),
        .DW    (DATA_W)
    ) u_buf (
        .clk       (clk),
        .rst       (rst),
        .clear     (unlock_open),
        .we        (load_accept),
        .widx      (byte_of(wr_addr)),
        .wdata     (wr_data),
        .ridx      (commit_idx),
        .rdata     (commit_byte),
        .any_valid (any_loaded)
    );

    always_comb begin
        rd_sector      = sector_of(rd_addr);
        rd_sector_mod  = rd_sector % SECT_NUM_W'(STORE_SECTORS);
        win_sector_mod = win_sector % SECT_NUM_W'(STORE_SECTORS);
        mem_raddr      = {rd_sector_mod[SEC_STO_W-1:0], byte_of(rd_addr)};
        mem_waddr      = {win_sector_mod[SEC_STO_W-1:0], commit_idx};
    end

    sws_cell_array #(
        .WORDS (ARR_WORDS),
        .DW    (DATA_W)
    ) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (commit_byte),
        .raddr (mem_raddr),
        .rdata (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            poll_toggle <= 1'b0;
            last_addr   <= '0;
            last_data   <= '0;
            win_sector  <= '0;
        end else begin
            if (busy && tick) poll_toggle <= ~poll_toggle;
            if (load_accept || stray_hit) begin
                last_addr <= wr_addr;
                last_data <= wr_data;
            end
            if (load_accept && !any_loaded) win_sector <= sector_of(wr_addr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            commit_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt        <= '0;
                    commit_idx <= '0;
                    if (unlock_open)    state <= ST_LOAD;
                    else if (stray_hit) state <= ST_STRAY;
                end
                ST_LOAD: begin
                    if (wr_stb) begin
                        cnt <= '0;
                    end else if (tick) begin
                        if (cnt == IDLE_LAST) begin
                            cnt   <= '0;
                            state <= ST_PROG;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_PROG: begin
                    if (tick) begin
                        if (cnt == PROG_LAST) begin
                            cnt        <= '0;
                            commit_idx <= '0;
                            state      <= any_loaded ? ST_COMMIT : ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_COMMIT: begin
                    commit_idx <= commit_idx + 1'b1;
                    if (commit_idx == IDX_LAST) state <= ST_IDLE;
                end
                ST_STRAY: begin
                    if (tick) begin
                        if (cnt == PROG_LAST) begin
                            cnt   <= '0;
                            state <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sws_checker.sv
module sws_checker
    import sws_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  tick,
    input logic                  wr_stb,
    input logic                  busy,
    input logic                  poll_toggle,
    input logic [15:0]           last_addr,
    input logic [7:0]            last_data,
    input logic                  mem_we,
    input logic [BYTE_IDX_W-1:0] commit_idx,
    input logic                  load_accept,
    input logic [SECT_NUM_W-1:0] win_sector
);

    assert_busy_ignores_writes_R8: assert property (@(posedge clk) disable iff (rst)
        busy && wr_stb |=> $stable(last_addr) && $stable(last_data));

    assert_commit_ascending_R7: assert property (@(posedge clk) disable iff (rst)
        mem_we && $past(mem_we) |-> commit_idx == BYTE_IDX_W'($past(commit_idx) + 1'b1));

    assert_toggle_flips_R9: assert property (@(posedge clk) disable iff (rst)
        busy && tick |=> poll_toggle != $past(poll_toggle));

    assert_toggle_holds_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(poll_toggle));

    assert_load_in_window_sector_R5: assert property (@(posedge clk) disable iff (rst)
        load_accept |=> last_addr[15:7] == win_sector);

endmodule

bind sector_write_seq sws_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .wr_stb      (wr_stb),
    .busy        (busy),
    .poll_toggle (poll_toggle),
    .last_addr   (last_addr),
    .last_data   (last_data),
    .mem_we      (mem_we),
    .commit_idx  (commit_idx),
    .load_accept (load_accept),
    .win_sector  (win_sector)
);

// File: tb/sector_write_seq_tb.sv
module sector_write_seq_tb;

    localparam int IDLE_T = 20;
    localparam int PROG_T = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b1;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] rd_addr = '0;
    logic [7:0]  rd_data;
    logic        busy;
    logic        poll_toggle;
    logic [15:0] last_addr;
    logic [7:0]  last_data;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [15:0] addr;
        logic [7:0]  exp;
        string       tag;
    } rd_item_t;

    rd_item_t rd_q[$];
    logic     rd_req = 1'b0;
    logic     rd_pend = 1'b0;

    always #4 clk = ~clk;

    sector_write_seq #(
        .IDLE_TICKS    (IDLE_T),
        .PROG_TICKS    (PROG_T),
        .STORE_SECTORS (16)
    ) u_dut (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .wr_stb      (wr_stb),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .busy        (busy),
        .poll_toggle (poll_toggle),
        .last_addr   (last_addr),
        .last_data   (last_data)
    );

    task automatic check_eq(input string tag, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic drv_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic unlock();
        drv_write(16'h5555, 8'hAA);
        drv_write(16'h2AAA, 8'h55);
        drv_write(16'h5555, 8'hA0);
    endtask

    task automatic rd_expect(input logic [15:0] a, input logic [7:0] e, input string tag);
        rd_item_t it;
        @(negedge clk);
        it.addr = a;
        it.exp  = e;
        it.tag  = tag;
        rd_q.push_back(it);
        rd_addr = a;
        rd_req  = 1'b1;
        @(negedge clk);
        rd_req  = 1'b0;
    endtask

    task automatic wait_busy(input string tag);
        int n = 0;
        while (!busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check_eq(tag, "busy reached", {31'd0, busy}, 32'd1);
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check_eq(tag, "busy cleared", {31'd0, busy}, 32'd0);
    endtask

    always @(posedge clk) rd_pend <= rd_req;

    always @(negedge clk) begin
        if (rd_pend) begin
            if (rd_q.size() == 0) begin
                check_eq("R13", "scoreboard underflow", 32'd1, 32'd0);
            end else begin
                rd_item_t it;
                it = rd_q.pop_front();
                check_eq(it.tag, $sformatf("array[%04h]", it.addr), {24'd0, rd_data}, {24'd0, it.exp});
            end
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic t0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_eq("R1", "busy", {31'd0, busy}, 32'd0);
        check_eq("R1", "poll_toggle", {31'd0, poll_toggle}, 32'd0);
        check_eq("R1", "last_addr", {16'd0, last_addr}, 32'd0);
        check_eq("R1", "last_data", {24'd0, last_data}, 32'd0);

        // R2 full prefix, R4 out-of-order loads into sector 3
        unlock();
        check_eq("R2", "busy after prefix", {31'd0, busy}, 32'd0);
        drv_write(16'h0185, 8'h11);
        check_eq("R11", "last_addr", {16'd0, last_addr}, 32'h0185);
        check_eq("R11", "last_data", {24'd0, last_data}, 32'h11);
        drv_write(16'h0182, 8'h22);
        drv_write(16'h01E4, 8'h33);
        drv_write(16'h0182, 8'h44);
        check_eq("R4", "last_data overwrite", {24'd0, last_data}, 32'h44);
        // R5 other sector discarded
        drv_write(16'h0389, 8'h42);
        check_eq("R5", "last_addr kept", {16'd0, last_addr}, 32'h0182);
        check_eq("R5", "last_data kept", {24'd0, last_data}, 32'h44);
        // R6 timeout counted from the discarded write
        repeat (IDLE_T - 1) @(negedge clk);
        check_eq("R6", "busy one before timeout", {31'd0, busy}, 32'd0);
        @(negedge clk);
        check_eq("R6", "busy at timeout", {31'd0, busy}, 32'd1);
        // R8 write while busy ignored
        drv_write(16'h0180, 8'h99);
        check_eq("R8", "last_addr", {16'd0, last_addr}, 32'h0182);
        // R9 toggle flips while busy
        t0 = poll_toggle;
        @(negedge clk);
        check_eq("R9", "toggle flipped", {31'd0, poll_toggle}, {31'd0, ~t0});
        // now 3 edges into the program period
        repeat (PROG_T + 128 - 4) @(negedge clk);
        check_eq("R7", "busy at last commit", {31'd0, busy}, 32'd1);
        @(negedge clk);
        check_eq("R7", "busy after commit", {31'd0, busy}, 32'd0);
        t0 = poll_toggle;
        repeat (3) @(negedge clk);
        check_eq("R9", "toggle held idle", {31'd0, poll_toggle}, {31'd0, t0});
        rd_expect(16'h0182, 8'h44, "R4");
        rd_expect(16'h0185, 8'h11, "R4");
        rd_expect(16'h01E4, 8'h33, "R4");
        rd_expect(16'h0189, 8'hFF, "R5");
        rd_expect(16'h0180, 8'hFF, "R8");
        rd_expect(16'h01FF, 8'hFF, "R7");

        // R3 and R12: plain write with no prefix
        drv_write(16'h0185, 8'h00);
        check_eq("R3", "stray busy", {31'd0, busy}, 32'd1);
        check_eq("R3", "stray last_addr", {16'd0, last_addr}, 32'h0185);
        check_eq("R3", "stray last_data", {24'd0, last_data}, 32'h00);
        repeat (PROG_T - 1) @(negedge clk);
        check_eq("R3", "stray busy end-1", {31'd0, busy}, 32'd1);
        @(negedge clk);
        check_eq("R3", "stray busy end", {31'd0, busy}, 32'd0);
        rd_expect(16'h0185, 8'h11, "R12");

        // R3 wrong second step
        drv_write(16'h5555, 8'hAA);
        check_eq("R2", "first step no busy", {31'd0, busy}, 32'd0);
        drv_write(16'h2AAB, 8'h55);
        check_eq("R3", "bad step busy", {31'd0, busy}, 32'd1);
        wait_idle("R3");
        rd_expect(16'h0182, 8'h44, "R3");

        // R7 reprogram erases unloaded bytes
        unlock();
        drv_write(16'h0187, 8'h5A);
        wait_busy("R7");
        wait_idle("R7");
        rd_expect(16'h0187, 8'h5A, "R7");
        rd_expect(16'h0182, 8'hFF, "R7");
        rd_expect(16'h0185, 8'hFF, "R7");

        // R10 tick low freezes timer, R13 sector aliasing
        unlock();
        drv_write(16'h0A01, 8'h3C);
        tick = 1'b0;
        repeat (3 * IDLE_T) @(negedge clk);
        check_eq("R10", "busy frozen", {31'd0, busy}, 32'd0);
        tick = 1'b1;
        wait_busy("R10");
        wait_idle("R10");
        rd_expect(16'h0201, 8'h3C, "R13");
        rd_expect(16'h0A01, 8'h3C, "R13");

        repeat (4) @(negedge clk);
        check_eq("R13", "scoreboard drained", rd_q.size(), 32'd0);
        finish_run();
    end

endmodule